// File: doc/BRIEF.md
# Three-wire serial EEPROM slave

This block models a 1 Kbit serial EEPROM that is driven over three wires: a chip select, a serial clock and a serial data input. It answers on a data output that it drives only while it has something to say. A strap input picks one of two organizations: 64 words of 16 bits or 128 words of 8 bits. The array is held in registers. The serial pins are sampled by the block's own system clock, and their edges are found in that clock domain.

A host starts every command with a start bit, then sends a two-bit opcode, an address and, where the command needs it, data. The block supports read, write and word erase. Under the all-zero opcode it also supports four extended commands: enable programming, disable programming, erase all and write all. A read returns a leading zero bit and then the data MSB first. The read moves on to the next word for as long as chip select stays high.

Every programming command starts a self-timed cycle whose length is a count of system clocks. The host watches the data output for a busy or ready level. The cycle is guarded by an enable latch, and that latch is cleared at reset.

Top module: `uwire_eeprom`

## Requirements
- R1: After reset the data output is not driven (`do_oe`=0), programming is disabled and every word of the array reads as all ones.
- R2: A command begins on the first rising serial-clock edge that sees both `cs` and `di` high. Rising edges before it with `di` low are ignored, and each one can be the place where the start bit lands.
- R3: After the start bit the host sends a two-bit opcode: 10 is read, 01 is write, 11 is erase and 00 is extended. Then come the address bits, MSB first: 6 when `org`=1 (16-bit words) and 7 when `org`=0 (8-bit words). For a write, the data bits follow MSB first. For an extended command, the two most significant address bits give the command: 11 enables programming, 00 disables it, 10 erases all and 01 writes all.
- R4: While programming is disabled, erase, write, erase-all and write-all leave the array unchanged. The enable command turns programming on, and it stays on until a disable command. Read works in either state.
- R5: Erase sets the addressed word to all ones. Erase-all sets every word to all ones. Write-all stores the supplied data in every word.
- R6: On the rising edge that delivers the last address bit of a read, the output is driven to 0 (the dummy bit). Each following rising edge presents the next data bit, MSB first. After the last bit of a word, the read continues with the next address, and the address wraps from the top word to word 0.
- R7: A programming cycle starts when `cs` falls after a complete frame. It lasts `PROG_CYCLES` system clocks, whatever `cs` and the serial clock do meanwhile.
- R8: Suppose a programming cycle has started and `cs` is raised after being low for at least `CSL_MIN` system clocks. The output is then driven, 0 while busy and 1 once ready. After a shorter low time it is not driven. It is never driven while `cs` is low.
- R9: Once the cycle is over, a start bit followed by `cs` going low stops the ready indication. The next time `cs` is raised, the output is not driven.
- R10: A command sent while a programming cycle is running is ignored.
- R11: Serial-clock edges beyond the bits a write frame needs are ignored.
- R12: With `org`=0 the same commands work on 8-bit words with 7-bit addresses. A read there wraps from address 127 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins and times programming |
| rst_n | input | 1 | Active-low reset |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data from the host |
| org | input | 1 | Organization strap: 1 gives 16-bit words, 0 gives 8-bit words |
| do_o | output | 1 | Serial data or ready/busy level |
| do_oe | output | 1 | Output enable for `do_o` (0 = high impedance) |

## Verification
Directed frames cover the following cases:
- programming while disabled and then enabled, which separates the enable latch from the write path;
- a short and a long `cs` low time before status polling, which separates a driven busy level from high impedance;
- a second write sent while busy, which shows whether commands are ignored during a cycle;
- leading zero clocks before a start bit, and extra trailing clocks after a write.

Sequential reads run across the top address in both organizations to check the wrap. Write-all followed by erase-all checks the bulk paths. Random writes, erases and reads against a word model then check that the addressing and data paths do not alias.

// File: rtl/uwire_eeprom.sv
module uwire_eeprom #(
  parameter int PROG_CYCLES = 400,
  parameter int CSL_MIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sck,
  input  logic di,
  input  logic org,
  output logic do_o,
  output logic do_oe
);
  localparam int TW = $clog2(PROG_CYCLES + 1);
  localparam int LW = $clog2(CSL_MIN + 1);
  localparam logic [2:0] C_NONE = 3'd0, C_EWEN = 3'd1, C_EWDS = 3'd2, C_ERASE = 3'd3,
                         C_ERAL = 3'd4, C_WRITE = 3'd5, C_WRAL = 3'd6;

  logic [2:0] cs_r, sck_r;
  logic [1:0] di_r;
  logic [7:0] mem [128];
  logic started, done, reading, sb_seen, wen, busy, pend, st_vis, dout;
  logic [4:0] cnt, rleft;
  logic [14:0] sr;
  logic [2:0] cmd;
  logic [6:0] adr, raddr;
  logic [15:0] wdat, rword;
  logic [TW-1:0] tmr;
  logic [LW-1:0] lowcnt;

  wire cs_s = cs_r[1];
  wire cs_fall = cs_r[2] & ~cs_r[1];
  wire cs_rise = ~cs_r[2] & cs_r[1];
  wire sck_rise = sck_r[1] & ~sck_r[2];
  wire di_s = di_r[1];

  wire [15:0] nxt = {sr, di_s};
  wire [4:0] cn = cnt + 5'd1;
  wire [4:0] alen = org ? 5'd8 : 5'd9;
  wire [4:0] dlen = org ? 5'd24 : 5'd17;
  wire [1:0] op = org ? nxt[7:6] : nxt[8:7];
  wire [1:0] ext = org ? nxt[5:4] : nxt[6:5];
  wire [6:0] na = org ? {1'b0, nxt[5:0]} : nxt[6:0];
  wire [6:0] ra_n = org ? {1'b0, raddr[5:0] + 6'd1} : raddr + 7'd1;
  wire [4:0] wbits = org ? 5'd16 : 5'd8;
  wire [2:0] kind = (op == 2'b11) ? C_ERASE : (op == 2'b01) ? C_WRITE :
                    (op == 2'b10) ? C_NONE  : (ext == 2'b11) ? C_EWEN :
                    (ext == 2'b00) ? C_EWDS : (ext == 2'b10) ? C_ERAL : C_WRAL;

  function automatic logic [15:0] fetch(input logic [6:0] a);
    fetch = org ? {mem[{a[5:0], 1'b0}], mem[{a[5:0], 1'b1}]} : {8'h00, mem[a]};
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_r <= '0; sck_r <= '0; di_r <= '0;
    end else begin
      cs_r <= {cs_r[1:0], cs}; sck_r <= {sck_r[1:0], sck}; di_r <= {di_r[0], di};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mem[i] <= 8'hFF;
      started <= 0; done <= 0; reading <= 0; sb_seen <= 0; wen <= 0; busy <= 0;
      pend <= 0; st_vis <= 0; dout <= 0; cnt <= '0; rleft <= '0; sr <= '0;
      cmd <= C_NONE; adr <= '0; raddr <= '0; wdat <= '0; rword <= '0;
      tmr <= '0; lowcnt <= '0;
    end else begin
      if (cs_s) lowcnt <= '0;
      else if (lowcnt < LW'(CSL_MIN)) lowcnt <= lowcnt + 1'b1;

      if (!cs_s) st_vis <= 0;
      else if (cs_rise) st_vis <= pend && (lowcnt >= LW'(CSL_MIN));

      if (!cs_s) begin
        started <= 0; done <= 0; reading <= 0; cnt <= '0; sb_seen <= 0;
      end else if (sck_rise) begin
        if (reading) begin
          dout <= org ? rword[15] : rword[7];
          if (rleft == 5'd1) begin
            raddr <= ra_n; rword <= fetch(ra_n); rleft <= wbits;
          end else begin
            rword <= rword << 1; rleft <= rleft - 5'd1;
          end
        end else if (!started) begin
          if (di_s && !busy) begin
            started <= 1; sb_seen <= 1; cnt <= '0; sr <= '0; cmd <= C_NONE;
          end
        end else if (!done) begin
          sr <= nxt[14:0];
          cnt <= cn;
          if (cn == alen) begin
            adr <= na;
            cmd <= kind;
            if (op == 2'b10) begin
              reading <= 1; dout <= 0; raddr <= na; rword <= fetch(na);
              rleft <= wbits; done <= 1;
            end else if (kind != C_WRITE && kind != C_WRAL) done <= 1;
          end else if (cn == dlen) begin
            wdat <= org ? nxt : {8'h00, nxt[7:0]};
            done <= 1;
          end
        end
      end

      if (busy) begin
        if (tmr == TW'(PROG_CYCLES - 1)) busy <= 0;
        else tmr <= tmr + 1'b1;
      end

      if (cs_fall && sb_seen && !busy) pend <= 0;

      if (cs_fall && done && !busy) begin
        case (cmd)
          C_EWEN: wen <= 1;
          C_EWDS: wen <= 0;
          C_ERASE, C_WRITE, C_ERAL, C_WRAL:
            if (wen) begin
              busy <= 1; tmr <= '0; pend <= 1;
              if (cmd == C_ERAL || cmd == C_WRAL) begin
                for (int i = 0; i < 128; i++)
                  mem[i] <= (cmd == C_ERAL) ? 8'hFF :
                            (org && (i % 2 == 0)) ? wdat[15:8] : wdat[7:0];
              end else if (org) begin
                mem[{adr[5:0], 1'b0}] <= (cmd == C_ERASE) ? 8'hFF : wdat[15:8];
                mem[{adr[5:0], 1'b1}] <= (cmd == C_ERASE) ? 8'hFF : wdat[7:0];
              end else
                mem[adr] <= (cmd == C_ERASE) ? 8'hFF : wdat[7:0];
            end
          default: ;
        endcase
      end
    end

  assign do_oe = cs_s & (reading | st_vis);
  assign do_o = reading ? dout : ~busy;

  // R7
  prog_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_fall));
  // R4
  wen_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wen);
  // R6
  dummy_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reading) |-> (do_oe && !do_o));
  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cs_s && sck_rise && !started) |=> !started);
  // R11
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 5'd24);
endmodule

// File: tb/uwire_eeprom_tb_top.sv
module uwire_eeprom_tb_top;
  localparam int PROG = 400;
  logic clk = 0, rst_n = 0, cs = 0, sck = 0, di = 0, org = 1;
  logic do_o, do_oe;
  logic so_v, so_e;
  int checks = 0, errors = 0;
  bit finished = 0;
  bit wen_m = 0;
  logic [15:0] m16 [64];
  logic [7:0] m8 [128];

  uwire_eeprom #(.PROG_CYCLES(PROG), .CSL_MIN(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sck(sck), .di(di), .org(org),
    .do_o(do_o), .do_oe(do_oe));

  always #5 clk = ~clk;

  function automatic int wmask();
    return org ? 63 : 127;
  endfunction

  function automatic logic [15:0] exp_word(input int a);
    return org ? m16[a & 63] : {8'h00, m8[a & 127]};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sbit(input logic b);
    @(negedge clk); di = b; sck = 0;
    repeat (3) @(negedge clk);
    so_v = do_o; so_e = do_oe;
    sck = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_up();
    @(negedge clk); sck = 0; cs = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_down(input int n);
    @(negedge clk); sck = 0; cs = 0; di = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic o);
    @(negedge clk); rst_n = 0; cs = 0; sck = 0; di = 0; org = o;
    repeat (4) @(negedge clk); rst_n = 1;
    repeat (2) @(negedge clk);
    wen_m = 0;
    for (int i = 0; i < 64; i++) m16[i] = 16'hFFFF;
    for (int i = 0; i < 128; i++) m8[i] = 8'hFF;
  endtask

  task automatic frame(input logic [1:0] op, input int a, input bit hasd,
                       input logic [15:0] d, input int extra);
    int aw = org ? 6 : 7;
    int w = org ? 16 : 8;
    cs_up();
    sbit(1); sbit(op[1]); sbit(op[0]);
    for (int i = aw - 1; i >= 0; i--) sbit(a[i]);
    if (hasd) for (int i = w - 1; i >= 0; i--) sbit(d[i]);
    for (int i = 0; i < extra; i++) sbit(1);
  endtask

  task automatic model(input logic [1:0] op, input int a, input logic [15:0] d,
                       output bit prog);
    logic [1:0] e = org ? a[5:4] : a[6:5];
    prog = 0;
    if (op == 2'b00 && e == 2'b11) wen_m = 1;
    else if (op == 2'b00 && e == 2'b00) wen_m = 0;
    else if (wen_m) begin
      prog = 1;
      for (int i = 0; i <= wmask(); i++) begin
        logic [15:0] v;
        if (op == 2'b00 && e == 2'b10) v = 16'hFFFF;
        else if (op == 2'b00) v = d;
        else if (i == (a & wmask())) v = (op == 2'b11) ? 16'hFFFF : d;
        else v = exp_word(i);
        if (org) m16[i] = v; else m8[i] = v[7:0];
      end
    end
  endtask

  task automatic wait_ready(input string tag);
    int n = 0;
    cs_up();
    chk(do_oe === 1'b1, {tag, " R8 status driven"}, do_oe, 1);
    while (do_o !== 1'b1 && n < PROG + 100) begin @(negedge clk); n++; end
    chk(do_o === 1'b1 && do_oe === 1'b1, {tag, " R7 ready reached"}, do_o, 1);
    sbit(1);
    cs_down(10);
  endtask

  task automatic prog(input logic [1:0] op, input int a, input logic [15:0] d,
                      input int extra, input string tag);
    bit p;
    bit hasd = (op == 2'b01) || (op == 2'b00 && (org ? a[5:4] : a[6:5]) == 2'b01);
    frame(op, a, hasd, d, extra);
    cs_down(10);
    model(op, a, d, p);
    if (p) wait_ready(tag);
  endtask

  task automatic rd(input int a, input int nw, input int lead, input string tag);
    int aw = org ? 6 : 7;
    int w = org ? 16 : 8;
    cs_up();
    for (int i = 0; i < lead; i++) sbit(0);
    sbit(1); sbit(1); sbit(0);
    for (int i = aw - 1; i >= 0; i--) sbit(a[i]);
    sbit(0);
    chk(so_e === 1'b1 && so_v === 1'b0, {tag, " R6 dummy zero"}, {so_e, so_v}, 2);
    for (int k = 0; k < nw; k++) begin
      logic [15:0] v = '0;
      logic [15:0] ex = exp_word((a + k) & wmask());
      for (int j = 0; j < w; j++) begin sbit(0); v = {v[14:0], so_v}; end
      chk(v === ex, {tag, " R6 read data"}, v, ex);
    end
    cs_down(10);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R7 actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    do_reset(1);
    chk(do_oe === 1'b0, "R1 output idle after reset", do_oe, 0);
    rd(5, 1, 0, "R1 erased after reset");
    prog(2'b01, 3, 16'h1234, 0, "R4 disabled write");
    rd(3, 1, 0, "R4 write ignored while disabled");
    prog(2'b00, 6'b110000, 0, 0, "R3 enable");

    frame(2'b01, 3, 1, 16'h1234, 0);
    cs_down(2);
    cs_up();
    chk(do_oe === 1'b0, "R8 short low time keeps output off", do_oe, 0);
    cs_down(10);
    cs_up();
    chk(do_oe === 1'b1 && do_o === 1'b0, "R8 busy level", {do_oe, do_o}, 2);
    cs_down(10);
    begin bit p; model(2'b01, 3, 16'h1234, p); end
    wait_ready("R7 write");
    cs_up();
    chk(do_oe === 1'b0, "R9 ready cleared", do_oe, 0);
    cs_down(10);
    rd(3, 1, 0, "R3 write x16");

    frame(2'b01, 8, 1, 16'hAAAA, 0); cs_down(10);
    frame(2'b01, 9, 1, 16'h5555, 0); cs_down(10);
    begin bit p; model(2'b01, 8, 16'hAAAA, p); end
    wait_ready("R10 busy");
    rd(8, 2, 0, "R10 command while busy ignored");

    prog(2'b01, 10, 16'h0F0F, 5, "R11 extra bits");
    rd(10, 1, 0, "R11 extra bits ignored");
    rd(10, 1, 3, "R2 leading zero clocks");
    prog(2'b01, 63, 16'hBEEF, 0, "R6 top");
    rd(63, 2, 0, "R6 wrap x16");
    prog(2'b11, 3, 0, 0, "R5 erase");
    rd(2, 3, 0, "R5 erase word");
    prog(2'b00, 6'b010000, 16'hC3C3, 0, "R5 wral");
    rd(30, 4, 0, "R5 write all");
    prog(2'b00, 6'b100000, 0, 0, "R5 eral");
    rd(0, 2, 0, "R5 erase all");

    for (int it = 0; it < 40; it++) begin
      int a = $urandom_range(0, 63);
      int c = $urandom_range(0, 4);
      logic [15:0] d = 16'($urandom());
      if (c <= 1) prog(2'b01, a, d, 0, "R3 random write");
      else if (c == 2) prog(2'b11, a, 0, 0, "R5 random erase");
      else rd(a, 2, $urandom_range(0, 2), "R6 random read");
    end
    rd(0, 64, 0, "R3 random full sweep");

    prog(2'b00, 6'b000000, 0, 0, "R4 disable");
    prog(2'b01, 1, 16'h0000, 0, "R4 write after disable");
    rd(1, 1, 0, "R4 read after disable");

    do_reset(0);
    rd(127, 1, 0, "R12 erased x8");
    prog(2'b00, 7'b1100000, 0, 0, "R12 enable");
    prog(2'b01, 127, 16'h00A5, 0, "R12 write");
    rd(127, 2, 0, "R12 wrap x8");
    prog(2'b01, 64, 16'h003C, 0, "R12 write hi");
    rd(63, 3, 0, "R12 mid read");
    prog(2'b00, 7'b0100000, 16'h005A, 0, "R12 wral");
    rd(100, 3, 0, "R12 write all x8");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule